// File: doc/BRIEF.md
# Windowed-Power Thermal Throttle Trigger

This block stands in for a die temperature sensor. It takes one power sample per valid strobe and keeps a sliding window of the most recent samples. It compares the window total with two programmable levels. Crossing the lower level arms a throttle request. After a programmable initiation delay the request is raised, and it is then held for a programmable minimum period before the block looks again at whether the heat estimate has cooled. Crossing the higher level raises an emergency flag at once. Two saturating counters record how many cycles were spent throttled and how many were spent in emergency.

The window has two selectable lengths: a short one that reacts quickly and a long one that smooths out brief spikes. No divider is used. The window total is compared with the threshold multiplied by the window length, and the threshold is a per-sample power value. Software sets the configuration inputs once at start-up. The throttle amount is passed to the pipeline only while the request is engaged. An initiation delay of zero models a trigger wired straight into pipeline control. A delay of a few hundred cycles models an interrupt-driven response.

Top module: `thermo_trigger_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state: after that edge `throttle_o`, `emergency_o`, `throttle_amt_o` and both counters are 0, and the window holds only zero samples.
- R2: The window total is the sum of the last N accepted samples, where samples not yet received count as 0. A sample is accepted at a rising edge where `smp_valid` is 1. A cycle with `smp_valid` low does not advance the window.
- R3: The block treats the average as over the trigger level only when the window total is strictly greater than `cfg_thr_trig` × N. A total exactly equal to that product does not trigger.
- R4: `emergency_o` is 1 exactly when the window total is strictly greater than `cfg_thr_emerg` × N. It reflects the samples accepted up to the most recent edge, with no further register delay.
- R5: With `cfg_init_dly` = 0, `throttle_o` rises one edge after the first edge at which the total is over the trigger level.
- R6: With `cfg_init_dly` = D > 0, `throttle_o` rises D edges later than under R5. It rises even if the total falls back below the trigger level during those D cycles.
- R7: Once raised, `throttle_o` stays high for at least `cfg_pol_dly` + 1 cycles. If the total is still over the trigger level at the end of that period, a further period of the same length begins.
- R8: At the end of a hold period, if the total is not over the trigger level, `throttle_o` falls at the next edge.
- R9: `throttle_amt_o` equals `cfg_thr_amt` while `throttle_o` is 1, and equals 0 otherwise.
- R10: `trig_cycles_o` increments at each edge where `throttle_o` was 1 before that edge. It saturates at 2^CNT_W − 1.
- R11: `emerg_cycles_o` increments at each edge where `emergency_o` was 1 before that edge. It saturates at 2^CNT_W − 1.
- R12: `cfg_win_long` = 1 selects N = LONG_WIN (64 by default). `cfg_win_long` = 0 selects N = SHORT_WIN (16 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Power sample strobe |
| smp_pwr | input | P_W | Per-sample power value |
| cfg_win_long | input | 1 | 1 = long window, 0 = short window |
| cfg_thr_trig | input | P_W | Trigger level, per-sample units |
| cfg_thr_emerg | input | P_W | Emergency level, per-sample units |
| cfg_init_dly | input | DLY_W | Initiation delay in cycles |
| cfg_pol_dly | input | DLY_W | Minimum hold period minus one, in cycles |
| cfg_thr_amt | input | AMT_W | Throttle amount forwarded while engaged |
| throttle_o | output | 1 | Throttle request |
| throttle_amt_o | output | AMT_W | Throttle amount, 0 when idle |
| emergency_o | output | 1 | Emergency level exceeded |
| trig_cycles_o | output | CNT_W | Saturating count of throttled cycles |
| emerg_cycles_o | output | CNT_W | Saturating count of emergency cycles |

## Verification
- A steady input exactly at the trigger level separates strict from non-strict comparison.
- A single large sample followed by a flush of zeros separates zero-delay from delayed engagement. It also shows that arming continues after the estimate has already cooled.
- Sparse strobes with gaps, together with a burst that crosses only the short window, show whether the window advances per strobe rather than per cycle, and whether the length selection is honoured.
- A long run with both levels at zero drives both counters into saturation.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    // Engagement controller states
    typedef enum logic [1:0] {
        TH_IDLE = 2'd0,
        TH_ARM  = 2'd1,
        TH_HOLD = 2'd2
    } th_state_e;

    // Result of comparing the window total with both levels
    typedef struct packed {
        logic over_trig;
        logic over_emerg;
    } th_cmp_t;

    // Width of a running total of up to 'win' samples of 'pw' bits
    function automatic int unsigned sum_width(int unsigned pw, int unsigned win);
        return pw + $clog2(win + 1);
    endfunction

endpackage

// File: rtl/thermo_window.sv
module thermo_window #(
    parameter int P_W       = 8,
    parameter int LONG_WIN  = 64,
    parameter int SHORT_WIN = 16,
    parameter int SUM_W     = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [P_W-1:0]   smp,
    output logic [SUM_W-1:0] sum_long,
    output logic [SUM_W-1:0] sum_short
);
    localparam int IDX_W = (LONG_WIN > 1) ? $clog2(LONG_WIN) : 1;

    logic [P_W-1:0]   ring [LONG_WIN];
    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] sh_idx;

    // Slot holding the sample that drops out of the short window
    always_comb begin
        if (int'(wr_ptr) >= SHORT_WIN)
            sh_idx = IDX_W'(int'(wr_ptr) - SHORT_WIN);
        else
            sh_idx = IDX_W'(int'(wr_ptr) + LONG_WIN - SHORT_WIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LONG_WIN; i++) ring[i] <= '0;
            wr_ptr    <= '0;
            sum_long  <= '0;
            sum_short <= '0;
        end else if (smp_valid) begin
            ring[wr_ptr] <= smp;
            wr_ptr       <= (int'(wr_ptr) == LONG_WIN - 1) ? '0 : wr_ptr + IDX_W'(1);
            sum_long     <= sum_long  + SUM_W'(smp) - SUM_W'(ring[wr_ptr]);
            sum_short    <= sum_short + SUM_W'(smp) - SUM_W'(ring[sh_idx]);
        end
    end

    initial begin
        if (SHORT_WIN >= LONG_WIN || SHORT_WIN < 1)
            $error("thermo_window: SHORT_WIN must lie in 1..LONG_WIN-1");
    end

    // R2: the short window is a subset of the long one
    p_short_le_long_r2: assert property (@(posedge clk) disable iff (rst)
        sum_short <= sum_long);

    // R2: no strobe, no movement of the window
    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(sum_long) && $stable(sum_short)));

    // R2: write pointer stays inside the ring
    p_ptr_range_r2: assert property (@(posedge clk) disable iff (rst)
        int'(wr_ptr) < LONG_WIN);

endmodule

// File: rtl/thermo_engage.sv
module thermo_engage
    import thermo_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             over_trig,
    input  logic [DLY_W-1:0] init_dly,
    input  logic [DLY_W-1:0] pol_dly,
    output logic             engaged
);
    th_state_e        st;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= TH_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                TH_IDLE: begin
                    if (over_trig) begin
                        if (init_dly == '0) begin
                            st  <= TH_HOLD;
                            cnt <= pol_dly;
                        end else begin
                            st  <= TH_ARM;
                            cnt <= init_dly;
                        end
                    end
                end
                TH_ARM: begin
                    if (cnt <= DLY_W'(1)) begin
                        st  <= TH_HOLD;
                        cnt <= pol_dly;
                    end else begin
                        cnt <= cnt - DLY_W'(1);
                    end
                end
                TH_HOLD: begin
                    if (cnt != '0)
                        cnt <= cnt - DLY_W'(1);
                    else if (!over_trig)
                        st <= TH_IDLE;
                    else
                        cnt <= pol_dly;
                end
                default: st <= TH_IDLE;
            endcase
        end
    end

    assign engaged = (st == TH_HOLD);

    // R8: release only after a cool check
    p_release_cool_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(engaged) |-> $past(!over_trig));

    // R5: zero-delay engagement needs a hot estimate one edge earlier
    p_zero_dly_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(engaged) && $past(st) == TH_IDLE) |-> $past(over_trig));

    // R6: arming always ends in engagement
    p_arm_to_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st == TH_ARM && cnt <= DLY_W'(1)) |=> engaged);

endmodule

// File: rtl/thermo_satcnt.sv
module thermo_satcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc && !(&cnt))
            cnt <= cnt + W'(1);
    end

    // R10 R11: a full counter stays full
    p_sat_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (&cnt) |=> (&cnt));

    // R11: the count never moves by more than one step
    p_single_step_r11: assert property (@(posedge clk) disable iff (rst)
        (cnt == $past(cnt)) || (cnt == $past(cnt) + W'(1)));

endmodule

// File: rtl/thermo_trigger_ctrl.sv
module thermo_trigger_ctrl
    import thermo_pkg::*;
#(
    parameter int P_W       = 8,
    parameter int LONG_WIN  = 64,
    parameter int SHORT_WIN = 16,
    parameter int DLY_W     = 10,
    parameter int CNT_W     = 12,
    parameter int AMT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [P_W-1:0]   smp_pwr,
    input  logic             cfg_win_long,
    input  logic [P_W-1:0]   cfg_thr_trig,
    input  logic [P_W-1:0]   cfg_thr_emerg,
    input  logic [DLY_W-1:0] cfg_init_dly,
    input  logic [DLY_W-1:0] cfg_pol_dly,
    input  logic [AMT_W-1:0] cfg_thr_amt,
    output logic             throttle_o,
    output logic [AMT_W-1:0] throttle_amt_o,
    output logic             emergency_o,
    output logic [CNT_W-1:0] trig_cycles_o,
    output logic [CNT_W-1:0] emerg_cycles_o
);
    localparam int SUM_W = sum_width(P_W, LONG_WIN);
    localparam int N_CNT = 2;

    logic [SUM_W-1:0] sum_long, sum_short, sum_sel, win_len;
    logic [SUM_W-1:0] lim_trig, lim_emerg;
    th_cmp_t          cmp;
    logic             engaged;

    thermo_window #(
        .P_W(P_W), .LONG_WIN(LONG_WIN), .SHORT_WIN(SHORT_WIN), .SUM_W(SUM_W)
    ) u_win (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp(smp_pwr),
        .sum_long(sum_long), .sum_short(sum_short)
    );

    // Compare total against level x length instead of dividing
    always_comb begin
        win_len       = cfg_win_long ? SUM_W'(LONG_WIN) : SUM_W'(SHORT_WIN);
        sum_sel       = cfg_win_long ? sum_long : sum_short;
        lim_trig      = SUM_W'(cfg_thr_trig)  * win_len;
        lim_emerg     = SUM_W'(cfg_thr_emerg) * win_len;
        cmp.over_trig  = sum_sel > lim_trig;
        cmp.over_emerg = sum_sel > lim_emerg;
    end

    thermo_engage #(.DLY_W(DLY_W)) u_eng (
        .clk(clk), .rst(rst), .over_trig(cmp.over_trig),
        .init_dly(cfg_init_dly), .pol_dly(cfg_pol_dly), .engaged(engaged)
    );

    assign throttle_o     = engaged;
    assign throttle_amt_o = engaged ? cfg_thr_amt : '0;
    assign emergency_o    = cmp.over_emerg;

    logic [N_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_val [N_CNT];
    assign inc_vec = {emergency_o, throttle_o};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        thermo_satcnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .inc(inc_vec[g]), .cnt(cnt_val[g])
        );
    end

    assign trig_cycles_o  = cnt_val[0];
    assign emerg_cycles_o = cnt_val[1];

    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!throttle_o && !emergency_o &&
                        trig_cycles_o == '0 && emerg_cycles_o == '0));

    // R4: emergency level above trigger level implies trigger condition
    p_emerg_implies_trig_r4: assert property (@(posedge clk) disable iff (rst)
        (emergency_o && cfg_thr_emerg >= cfg_thr_trig) |-> cmp.over_trig);

    // R9: no amount is forwarded while idle
    p_amt_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !throttle_o |-> (throttle_amt_o == '0));

    // R10: a throttled cycle advances the counter unless saturated
    p_trig_count_r10: assert property (@(posedge clk) disable iff (rst)
        (throttle_o && !(&trig_cycles_o)) |=> (trig_cycles_o != $past(trig_cycles_o)));

endmodule

// File: tb/sim_thermo_trigger_ctrl.sv
`timescale 1ns/1ps
module sim_thermo_trigger_ctrl;
    localparam int P_W = 8, LW = 64, SW = 16, DLY_W = 10, CNT_W = 12, AMT_W = 4;
    localparam int MAXC = (1 << CNT_W) - 1;

    logic clk = 0, rst = 1;
    logic smp_valid = 0;
    logic [P_W-1:0] smp_pwr = '0;
    logic cfg_win_long = 0;
    logic [P_W-1:0] cfg_thr_trig = 8'd10, cfg_thr_emerg = 8'd12;
    logic [DLY_W-1:0] cfg_init_dly = '0, cfg_pol_dly = 10'd3;
    logic [AMT_W-1:0] cfg_thr_amt = 4'd5;
    logic throttle_o, emergency_o;
    logic [AMT_W-1:0] throttle_amt_o;
    logic [CNT_W-1:0] trig_cycles_o, emerg_cycles_o;

    always #2 clk = ~clk;

    thermo_trigger_ctrl u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_pwr(smp_pwr),
        .cfg_win_long(cfg_win_long), .cfg_thr_trig(cfg_thr_trig),
        .cfg_thr_emerg(cfg_thr_emerg), .cfg_init_dly(cfg_init_dly),
        .cfg_pol_dly(cfg_pol_dly), .cfg_thr_amt(cfg_thr_amt),
        .throttle_o(throttle_o), .throttle_amt_o(throttle_amt_o),
        .emergency_o(emergency_o), .trig_cycles_o(trig_cycles_o),
        .emerg_cycles_o(emerg_cycles_o)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit started = 0;

    // Behavioural reference: newest sample at the front of the queue
    int hist[$];
    int m_st = 0, m_cnt = 0, m_tc = 0, m_ec = 0;

    function automatic int msum(int n);
        int s = 0;
        for (int i = 0; i < n && i < hist.size(); i++) s += hist[i];
        return s;
    endfunction

    function automatic int cur_n();
        return cfg_win_long ? LW : SW;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_st = 0; m_cnt = 0; m_tc = 0; m_ec = 0;
        end else begin
            int n, s;
            bit hot, emg;
            n = cur_n();
            s = msum(n);
            hot = s > int'(cfg_thr_trig) * n;
            emg = s > int'(cfg_thr_emerg) * n;
            if (m_st == 2 && m_tc < MAXC) m_tc++;
            if (emg && m_ec < MAXC) m_ec++;
            if (m_st == 0) begin
                if (hot) begin
                    if (cfg_init_dly == 0) begin m_st = 2; m_cnt = int'(cfg_pol_dly); end
                    else begin m_st = 1; m_cnt = int'(cfg_init_dly); end
                end
            end else if (m_st == 1) begin
                if (m_cnt <= 1) begin m_st = 2; m_cnt = int'(cfg_pol_dly); end
                else m_cnt--;
            end else begin
                if (m_cnt != 0) m_cnt--;
                else if (!hot) m_st = 0;
                else m_cnt = int'(cfg_pol_dly);
            end
            if (smp_valid) begin
                hist.push_front(int'(smp_pwr));
                if (hist.size() > LW) void'(hist.pop_back());
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (started && !rst) begin
            int n;
            bit e_emg;
            n = cur_n();
            e_emg = msum(n) > int'(cfg_thr_emerg) * n;
            chk(throttle_o == (m_st == 2), "R5 R6 R7 R8 throttle", int'(throttle_o), int'(m_st == 2));
            chk(emergency_o == e_emg, "R2 R4 emergency", int'(emergency_o), int'(e_emg));
            chk(int'(throttle_amt_o) == ((m_st == 2) ? int'(cfg_thr_amt) : 0), "R9 amount",
                int'(throttle_amt_o), (m_st == 2) ? int'(cfg_thr_amt) : 0);
            chk(int'(trig_cycles_o) == m_tc, "R10 trig count", int'(trig_cycles_o), m_tc);
            chk(int'(emerg_cycles_o) == m_ec, "R11 emerg count", int'(emerg_cycles_o), m_ec);
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            report();
        end
    end

    // Called at a negedge: sample is taken at the next edge, then observe
    task automatic step(bit v, int s);
        smp_valid = v; smp_pwr = P_W'(s);
        @(negedge clk);
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 0);
    endtask

    task automatic do_reset();
        smp_valid = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        started = 1;
        // R1
        chk(!throttle_o && !emergency_o && trig_cycles_o == 0 && emerg_cycles_o == 0,
            "R1 reset state", int'(throttle_o) + int'(emergency_o), 0);

        // R3: total exactly equal to level x N does not trigger
        for (int i = 0; i < 30; i++) step(1, 10);
        idle(4);
        chk(throttle_o == 0, "R3 equal not over", int'(throttle_o), 0);
        // push just over
        step(1, 11);
        idle(3);
        chk(throttle_o == 1, "R3 strictly over", int'(throttle_o), 1);
        for (int i = 0; i < 20; i++) step(i % 3 != 0, 25);
        for (int i = 0; i < 40; i++) step(i % 2, 0);
        idle(10);

        // R4 R5: single hot sample, zero initiation delay
        do_reset();
        step(1, 200);
        chk(throttle_o == 0, "R5 not yet engaged", int'(throttle_o), 0);
        chk(emergency_o == 1, "R4 emergency same cycle", int'(emergency_o), 1);
        step(0, 0);
        chk(throttle_o == 1, "R5 engaged one edge later", int'(throttle_o), 1);
        chk(int'(throttle_amt_o) == 5, "R9 amount forwarded", int'(throttle_amt_o), 5);
        for (int i = 0; i < 16; i++) step(1, 0);
        idle(12);
        chk(throttle_o == 0, "R8 released after cooling", int'(throttle_o), 0);

        // R6: delayed engagement proceeds although the estimate cooled
        do_reset();
        @(posedge clk); #1 cfg_init_dly = 10'd20; cfg_pol_dly = 10'd2; @(negedge clk);
        step(1, 200);
        for (int i = 0; i < 16; i++) step(1, 0);
        idle(4);
        chk(throttle_o == 0, "R6 still arming", int'(throttle_o), 0);
        step(0, 0);
        chk(throttle_o == 1, "R6 engaged after delay", int'(throttle_o), 1);
        idle(10);

        // R12: burst visible to the short window only
        do_reset();
        @(posedge clk); #1 cfg_win_long = 1; cfg_init_dly = '0; cfg_pol_dly = 10'd4; @(negedge clk);
        for (int i = 0; i < 10; i++) step(1, 40);
        idle(4);
        chk(throttle_o == 0, "R12 long window not hot", int'(throttle_o), 0);
        @(posedge clk); #1 cfg_win_long = 0; @(negedge clk);
        idle(1);
        chk(throttle_o == 1, "R12 short window hot", int'(throttle_o), 1);
        for (int i = 0; i < 70; i++) step(i % 4 != 3, (i * 37) % 60);
        idle(20);

        // Interrupt-like delay with mixed traffic
        @(posedge clk); #1 cfg_init_dly = 10'd250; cfg_pol_dly = 10'd40; cfg_thr_amt = 4'd9; @(negedge clk);
        for (int i = 0; i < 400; i++) step(i % 5 != 0, (i * 13) % 30);
        for (int i = 0; i < 100; i++) step(1, 0);
        idle(400);

        // R10 R11: saturation
        do_reset();
        @(posedge clk); #1 cfg_thr_trig = '0; cfg_thr_emerg = '0; cfg_init_dly = '0; cfg_pol_dly = '0;
        @(negedge clk);
        step(1, 255);
        idle(MAXC + 100);
        chk(int'(trig_cycles_o) == MAXC, "R10 trig count saturates", int'(trig_cycles_o), MAXC);
        chk(int'(emerg_cycles_o) == MAXC, "R11 emerg count saturates", int'(emerg_cycles_o), MAXC);

        report();
    end
endmodule